// File: doc/BRIEF.md
# Fused Multiply-Add NaN Selector

This block decides what a binary32 fused multiply-add `(a*b)+c` returns when at least one of its three operands is a NaN. It takes the three raw operands and three controls. The first control sets the polarity of the quiet bit. The second forces the default NaN. The third, a two-bit policy select, chooses which of four priority rules applies. From these it produces a two-bit selection code, the final quieted 32-bit NaN and an invalid-operation flag. The product `a*b` may be infinity times zero. The block detects this case itself and handles it as the policy requires.

The arithmetic datapath sends the operands with a valid strobe. The decision is registered and appears one clock later with its own valid. In this way the NaN path runs alongside the normal arithmetic without adding logic depth to it. The block makes no decision for operand sets that contain no NaN.

Top module: `fnan_sel`

## Requirements
- R1: `out_valid` is high exactly one cycle after a cycle with `in_valid` high. The registered outputs reflect the operands sampled in that cycle. After reset every output is zero.
- R2: An operand is a NaN when its eight exponent bits are all ones and its 23-bit fraction is non-zero. With `inv_pol`=0 it is quiet when fraction bit 22 is one and signaling when that bit is zero. With `inv_pol`=1 the two meanings are swapped.
- R3: `sel_code` 0 selects a, 1 selects b, 2 selects c and 3 selects the default NaN. The default NaN is 0x7FC00000 with `inv_pol`=0 and 0x7FBFFFFF with `inv_pol`=1.
- R4: With `policy`=0, an infinity-times-zero product together with a quiet-NaN c gives code 3 and raises invalid. Otherwise the first match wins in this order: signaling c, signaling a, signaling b, quiet c, quiet a, then b.
- R5: With `policy`=1, any infinity-times-zero product gives code 3 and raises invalid, whatever c holds.
- R6: With `policy`=1 and no infinity-times-zero product, the order depends on polarity. With `inv_pol`=1 it is signaling a, b, c, then quiet a, b, else c. With `inv_pol`=0 it is the order of R4.
- R7: With `policy`=2, an infinity-times-zero product gives code 2 and raises invalid. Otherwise the block picks a if a is any NaN, else c if c is any NaN, else b.
- R8: With `policy`=3 the block picks a if a is any NaN, else b if b is any NaN, else c.
- R9: `invalid` is raised whenever any operand is a signaling NaN, under every policy and mode.
- R10: A selected quiet NaN is passed through unchanged. A selected signaling NaN has fraction bit 22 set with `inv_pol`=0. With `inv_pol`=1 it is replaced by the default NaN, and the code is left as selected.
- R11: With `dnan_mode`=1 the code is 3 and the result is the default NaN. `invalid` is still reported as R4 to R9 require.
- R12: The product is infinity times zero when one of a, b has all exponent bits set and a zero fraction, and the other has a zero exponent and a zero fraction. The sign of either operand does not matter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | Multiplicand a |
| op_b | input | 32 | Multiplier b |
| op_c | input | 32 | Addend c |
| inv_pol | input | 1 | 1: fraction MSB set means signaling |
| dnan_mode | input | 1 | Force the default NaN result |
| policy | input | 2 | Priority rule, 0 to 3 as in R4 to R8 |
| out_valid | output | 1 | Registered decision is valid |
| sel_code | output | 2 | Selection code as in R3 |
| result | output | 32 | Final NaN after quieting |
| invalid | output | 1 | Invalid-operation flag |

## Verification
Two functions can act in the same cycle. The infinity-times-zero rule can coincide with a signaling-NaN addend. The default-NaN override can coincide with a signaling operand. The sweep crosses operand values that include infinity, negative zero, a finite number and three NaN patterns whose class flips with polarity. It runs these over every policy, polarity and mode setting, so both overlaps occur many times. Each overlap is judged separately on the code, which must follow the infinity-times-zero rule or the override, and on the invalid flag, which must stay raised for the signaling operand either way.

// File: rtl/fnan_pkg.sv
package fnan_pkg;

    typedef enum logic [1:0] {
        POL_ADDEND_FIRST = 2'd0,
        POL_BY_POLARITY  = 2'd1,
        POL_A_C_B        = 2'd2,
        POL_A_B_C        = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        SEL_A    = 2'd0,
        SEL_B    = 2'd1,
        SEL_C    = 2'd2,
        SEL_DFLT = 2'd3
    } sel_e;

    typedef struct packed {
        logic nan;
        logic qnan;
        logic snan;
        logic inf;
        logic zero;
    } fcls_t;

    // signaling c, a, b then quiet c, a, else b
    function automatic sel_e chain_cab(input fcls_t a, input fcls_t b, input fcls_t c);
        if (c.snan)      return SEL_C;
        else if (a.snan) return SEL_A;
        else if (b.snan) return SEL_B;
        else if (c.qnan) return SEL_C;
        else if (a.qnan) return SEL_A;
        else             return SEL_B;
    endfunction

    // signaling a, b, c then quiet a, b, else c
    function automatic sel_e chain_abc_sq(input fcls_t a, input fcls_t b, input fcls_t c);
        if (a.snan)      return SEL_A;
        else if (b.snan) return SEL_B;
        else if (c.snan) return SEL_C;
        else if (a.qnan) return SEL_A;
        else if (b.qnan) return SEL_B;
        else             return SEL_C;
    endfunction

    function automatic sel_e chain_acb_any(input fcls_t a, input fcls_t c);
        if (a.nan)      return SEL_A;
        else if (c.nan) return SEL_C;
        else            return SEL_B;
    endfunction

    function automatic sel_e chain_abc_any(input fcls_t a, input fcls_t b);
        if (a.nan)      return SEL_A;
        else if (b.nan) return SEL_B;
        else            return SEL_C;
    endfunction

endpackage

// File: rtl/fnan_classify.sv
module fnan_classify
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] op,
    input  logic                  inv_pol,
    output fcls_t                 cls
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_max, exp_zero, frac_nz, quiet_bit;

    always_comb begin
        expo      = op[W-2:FRAC_W];
        frac      = op[FRAC_W-1:0];
        exp_max   = &expo;
        exp_zero  = ~|expo;
        frac_nz   = |frac;
        quiet_bit = frac[FRAC_W-1] ^ inv_pol;
        cls.nan   = exp_max & frac_nz;
        cls.qnan  = exp_max & frac_nz & quiet_bit;
        cls.snan  = exp_max & frac_nz & ~quiet_bit;
        cls.inf   = exp_max & ~frac_nz;
        cls.zero  = exp_zero & ~frac_nz;
    end
endmodule

// File: rtl/fnan_pick.sv
module fnan_pick
    import fnan_pkg::*;
(
    input  fcls_t      cls_a,
    input  fcls_t      cls_b,
    input  fcls_t      cls_c,
    input  logic       inf_zero,
    input  logic       inv_pol,
    input  logic [1:0] policy,
    output sel_e       code,
    output logic       iz_invalid
);
    policy_e pol;

    always_comb begin
        pol        = policy_e'(policy);
        code       = SEL_B;
        iz_invalid = 1'b0;
        unique case (pol)
            POL_ADDEND_FIRST: begin
                if (inf_zero && cls_c.qnan) begin
                    iz_invalid = 1'b1;
                    code       = SEL_DFLT;
                end else begin
                    code = chain_cab(cls_a, cls_b, cls_c);
                end
            end
            POL_BY_POLARITY: begin
                if (inf_zero) begin
                    iz_invalid = 1'b1;
                    code       = SEL_DFLT;
                end else if (inv_pol) begin
                    code = chain_abc_sq(cls_a, cls_b, cls_c);
                end else begin
                    code = chain_cab(cls_a, cls_b, cls_c);
                end
            end
            POL_A_C_B: begin
                if (inf_zero) begin
                    iz_invalid = 1'b1;
                    code       = SEL_C;
                end else begin
                    code = chain_acb_any(cls_a, cls_c);
                end
            end
            POL_A_B_C: begin
                code = chain_abc_any(cls_a, cls_b);
            end
            default: code = SEL_B;
        endcase
    end
endmodule

// File: rtl/fnan_shape.sv
module fnan_shape
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  sel_e                  code_in,
    input  logic                  dnan_mode,
    input  logic                  inv_pol,
    input  logic [EXP_W+FRAC_W:0] op_a,
    input  logic [EXP_W+FRAC_W:0] op_b,
    input  logic [EXP_W+FRAC_W:0] op_c,
    input  fcls_t                 cls_a,
    input  fcls_t                 cls_b,
    input  fcls_t                 cls_c,
    output sel_e                  code_out,
    output logic [EXP_W+FRAC_W:0] res
);
    localparam int W = 1 + EXP_W + FRAC_W;
    localparam logic [W-1:0] DFLT_NRM = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] DFLT_INV = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};
    localparam logic [W-1:0] QBIT     = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [W-1:0] dflt, picked;
    logic         picked_sig;

    always_comb begin
        dflt = inv_pol ? DFLT_INV : DFLT_NRM;
        unique case (code_in)
            SEL_A:   begin picked = op_a; picked_sig = cls_a.snan; end
            SEL_B:   begin picked = op_b; picked_sig = cls_b.snan; end
            SEL_C:   begin picked = op_c; picked_sig = cls_c.snan; end
            default: begin picked = dflt; picked_sig = 1'b0;       end
        endcase
        if (dnan_mode || code_in == SEL_DFLT) begin
            code_out = SEL_DFLT;
            res      = dflt;
        end else begin
            code_out = code_in;
            if (!picked_sig)  res = picked;
            else if (inv_pol) res = dflt;
            else              res = picked | QBIT;
        end
    end
endmodule

// File: rtl/fnan_sel.sv
module fnan_sel
    import fnan_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [W-1:0] op_c,
    input  logic         inv_pol,
    input  logic         dnan_mode,
    input  logic [1:0]   policy,
    output logic         out_valid,
    output logic [1:0]   sel_code,
    output logic [W-1:0] result,
    output logic         invalid
);
    localparam int N_OPS = 3;

    logic [W-1:0] ops [N_OPS];
    fcls_t        cls [N_OPS];
    logic         inf_zero, iz_invalid, any_snan, nxt_invalid;
    sel_e         raw_code, fin_code;
    logic [W-1:0] nxt_result;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign ops[2] = op_c;

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fnan_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .op      (ops[gi]),
            .inv_pol (inv_pol),
            .cls     (cls[gi])
        );
    end

    always_comb begin
        inf_zero    = (cls[0].inf & cls[1].zero) | (cls[0].zero & cls[1].inf);
        any_snan    = cls[0].snan | cls[1].snan | cls[2].snan;
        nxt_invalid = any_snan | iz_invalid;
    end

    fnan_pick u_pick (
        .cls_a      (cls[0]),
        .cls_b      (cls[1]),
        .cls_c      (cls[2]),
        .inf_zero   (inf_zero),
        .inv_pol    (inv_pol),
        .policy     (policy),
        .code       (raw_code),
        .iz_invalid (iz_invalid)
    );

    fnan_shape #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_shape (
        .code_in   (raw_code),
        .dnan_mode (dnan_mode),
        .inv_pol   (inv_pol),
        .op_a      (op_a),
        .op_b      (op_b),
        .op_c      (op_c),
        .cls_a     (cls[0]),
        .cls_b     (cls[1]),
        .cls_c     (cls[2]),
        .code_out  (fin_code),
        .res       (nxt_result)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sel_code  <= 2'd0;
            result    <= '0;
            invalid   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sel_code <= fin_code;
                result   <= nxt_result;
                invalid  <= nxt_invalid;
            end
        end
    end
endmodule

// File: rtl/fnan_sel_chk.sv
module fnan_sel_chk #(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] op_a,
    input logic [W-1:0] op_b,
    input logic [W-1:0] op_c,
    input logic         inv_pol,
    input logic         dnan_mode,
    input logic [1:0]   policy,
    input logic         out_valid,
    input logic [1:0]   sel_code,
    input logic [W-1:0] result,
    input logic         invalid
);
    localparam logic [W-1:0] D_NRM = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [W-1:0] D_INV = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    function automatic logic is_nan(input logic [W-1:0] x);
        return (x[W-2:FRAC_W] == {EXP_W{1'b1}}) && (x[FRAC_W-1:0] != '0);
    endfunction
    function automatic logic is_sig(input logic [W-1:0] x, input logic ip);
        return is_nan(x) && (x[FRAC_W-1] == ip);
    endfunction
    function automatic logic is_inf(input logic [W-1:0] x);
        return (x[W-2:FRAC_W] == {EXP_W{1'b1}}) && (x[FRAC_W-1:0] == '0);
    endfunction
    function automatic logic is_zero(input logic [W-1:0] x);
        return x[W-2:0] == '0;
    endfunction

    logic has_nan, has_snan, iz;
    logic q_pol;

    always_comb begin
        has_nan  = is_nan(op_a) | is_nan(op_b) | is_nan(op_c);
        has_snan = is_sig(op_a, inv_pol) | is_sig(op_b, inv_pol) | is_sig(op_c, inv_pol);
        iz       = (is_inf(op_a) & is_zero(op_b)) | (is_zero(op_a) & is_inf(op_b));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q_pol <= 1'b0;
        else if (in_valid) q_pol <= inv_pol;
    end

    assert_latency_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_snan_invalid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && has_snan) |=> invalid);
    assert_dnan_code_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dnan_mode) |=> (sel_code == 2'd3));
    assert_dflt_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sel_code == 2'd3) |-> (result == (q_pol ? D_INV : D_NRM)));
    assert_quiet_out_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !inv_pol && has_nan) |=> result[FRAC_W-1]);
    assert_infzero_pol1_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && iz && policy == 2'd1) |=> (sel_code == 2'd3 && invalid));
    assert_acb_infzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && iz && policy == 2'd2 && !dnan_mode) |=> (sel_code == 2'd2 && invalid));
endmodule

bind fnan_sel fnan_sel_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .op_b      (op_b),
    .op_c      (op_c),
    .inv_pol   (inv_pol),
    .dnan_mode (dnan_mode),
    .policy    (policy),
    .out_valid (out_valid),
    .sel_code  (sel_code),
    .result    (result),
    .invalid   (invalid)
);

// File: tb/tb_fnan_sel.sv
`timescale 1ns/1ps
module tb_fnan_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        inv_pol = 1'b0, dnan_mode = 1'b0;
    logic [1:0]  policy = 2'd0;
    logic        out_valid;
    logic [1:0]  sel_code;
    logic [31:0] result;
    logic        invalid;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    fnan_sel dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .inv_pol(inv_pol), .dnan_mode(dnan_mode), .policy(policy),
        .out_valid(out_valid), .sel_code(sel_code), .result(result), .invalid(invalid)
    );

    logic [31:0] vals [6];
    initial begin
        vals[0] = 32'h7F80_0000; // +infinity
        vals[1] = 32'h8000_0000; // -zero
        vals[2] = 32'h3F80_0000; // finite
        vals[3] = 32'h7FC0_0001; // NaN, fraction MSB set
        vals[4] = 32'h7F80_0005; // NaN, fraction MSB clear
        vals[5] = 32'hFFE0_0000; // negative NaN, fraction MSB set
    end

    function automatic logic m_nan(input logic [31:0] x);
        return x[30:23] == 8'hFF && x[22:0] != 0;
    endfunction
    function automatic logic m_sig(input logic [31:0] x, input logic ip);
        return m_nan(x) && (x[22] == ip);
    endfunction
    function automatic logic m_qui(input logic [31:0] x, input logic ip);
        return m_nan(x) && (x[22] != ip);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic run_vec(input logic [31:0] a, b, c, input logic ip, dn, input logic [1:0] pc);
        logic [1:0]  ec;
        logic [31:0] er, dflt, pk;
        logic        ei, izi, iz, pk_sig;
        string       ctag;
        // R12: infinity times zero, either order, any sign
        iz  = ((a[30:0] == 31'h7F80_0000) && (b[30:0] == 0)) ||
              ((b[30:0] == 31'h7F80_0000) && (a[30:0] == 0));
        izi = 1'b0;
        dflt = ip ? 32'h7FBF_FFFF : 32'h7FC0_0000;
        case (pc)
            2'd0: begin
                ctag = "R4";
                if (iz && m_qui(c, ip)) begin ec = 3; izi = 1; end
                else if (m_sig(c, ip)) ec = 2;
                else if (m_sig(a, ip)) ec = 0;
                else if (m_sig(b, ip)) ec = 1;
                else if (m_qui(c, ip)) ec = 2;
                else if (m_qui(a, ip)) ec = 0;
                else ec = 1;
            end
            2'd1: begin
                ctag = iz ? "R5" : "R6";
                if (iz) begin ec = 3; izi = 1; end
                else if (ip) begin
                    if (m_sig(a, ip)) ec = 0;
                    else if (m_sig(b, ip)) ec = 1;
                    else if (m_sig(c, ip)) ec = 2;
                    else if (m_qui(a, ip)) ec = 0;
                    else if (m_qui(b, ip)) ec = 1;
                    else ec = 2;
                end else begin
                    if (m_sig(c, ip)) ec = 2;
                    else if (m_sig(a, ip)) ec = 0;
                    else if (m_sig(b, ip)) ec = 1;
                    else if (m_qui(c, ip)) ec = 2;
                    else if (m_qui(a, ip)) ec = 0;
                    else ec = 1;
                end
            end
            2'd2: begin
                ctag = "R7";
                if (iz) begin ec = 2; izi = 1; end
                else if (m_nan(a)) ec = 0;
                else if (m_nan(c)) ec = 2;
                else ec = 1;
            end
            default: begin
                ctag = "R8";
                if (m_nan(a)) ec = 0;
                else if (m_nan(b)) ec = 1;
                else ec = 2;
            end
        endcase
        ei = m_sig(a, ip) | m_sig(b, ip) | m_sig(c, ip) | izi;
        pk = (ec == 0) ? a : (ec == 1) ? b : c;
        pk_sig = m_sig(pk, ip);
        if (dn || ec == 3) begin
            ec = 3;
            er = dflt;
            if (dn) ctag = "R11";
        end else if (!pk_sig) er = pk;
        else if (ip) er = dflt;
        else er = pk | 32'h0040_0000;

        @(negedge clk);
        op_a = a; op_b = b; op_c = c;
        inv_pol = ip; dnan_mode = dn; policy = pc;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R1 out_valid", {31'b0, out_valid}, 32'd1);
        check(ctag, {30'b0, sel_code}, {30'b0, ec});
        // R2 classification and R3 default values feed the result check
        check((er == dflt) ? "R3 result" : "R10 result", result, er);
        check("R9 invalid", {31'b0, invalid}, {31'b0, ei});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        check("R1 rst valid", {31'b0, out_valid}, 32'd0);
        check("R1 rst code", {30'b0, sel_code}, 32'd0);
        check("R1 rst result", result, 32'd0);
        check("R1 rst invalid", {31'b0, invalid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle", {31'b0, out_valid}, 32'd0);

        for (int p = 0; p < 4; p++)
            for (int ipv = 0; ipv < 2; ipv++)
                for (int d = 0; d < 2; d++)
                    for (int ia = 0; ia < 6; ia++)
                        for (int ib = 0; ib < 6; ib++)
                            for (int ic = 0; ic < 6; ic++)
                                if (m_nan(vals[ia]) || m_nan(vals[ib]) || m_nan(vals[ic]))
                                    run_vec(vals[ia], vals[ib], vals[ic], ipv[0], d[0], p[1:0]);

        @(negedge clk);
        check("R1 drop valid", {31'b0, out_valid}, 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule